// File: doc/BRIEF.md
# Dual-Slope PWM Compare Unit

This block is a 16-bit up/down timer running in dual-slope (phase-correct) mode. It drives three compare output pins, A, B and C. The counter climbs from zero to a programmable TOP value and then falls back to zero, and it repeats that sweep for as long as the count enable is high. Each channel compares the running count against its own buffered compare value. On a match it sets, clears or toggles its pin. Which action it takes depends on the channel's 2-bit output-mode field and on whether the count was rising or falling when the match happened. The result is a centre-aligned pulse whose width follows the compare value and whose edges sit symmetrically around the bottom of each sweep.

Each channel reports an output-enable flag next to its pin. When the flag is low, the timer does not own the pin and the surrounding port logic keeps control of it. A 4-bit waveform-select input only affects the toggle mode, which exists on channel A alone.

Top module: `dslope_pwm`

## Requirements
- R1: Output-mode code 2'b00 makes a channel's output-enable low, and its pin register keeps its previous value.
- R2: Output-mode code 2'b10 sets the output-enable high. A match seen while the count is rising drives the pin to 0, and a match seen while it is falling drives the pin to 1.
- R3: Output-mode code 2'b11 sets the output-enable high. A match seen while rising drives the pin to 1, and a match seen while falling drives it to 0.
- R4: Output-mode code 2'b01 with waveform select 9 or 11 makes channel A toggle its pin on every match, in either direction, with its output-enable high. Channels B and C in code 2'b01 keep their output-enable low.
- R5: Output-mode code 2'b01 with any other waveform select leaves every channel's output-enable low.
- R6: A buffered compare value at or above TOP overrides all other conditions. In code 2'b10 it forces the pin to 1 on every enabled clock, and in code 2'b11 it forces the pin to 0.
- R7: A buffered compare value of zero, with TOP above zero, forces the pin to 0 on every enabled clock in code 2'b10 and to 1 in code 2'b11.
- R8: The count runs 0, 1, … TOP, TOP−1, … 1, 0, 1, … with each end value held for exactly one enabled clock. When TOP is 0, the count stays at 0 and keeps rising.
- R9: Each compare input is copied into that channel's buffered compare value only on an enabled clock where the count is at or above TOP while rising.
- R10: A match is evaluated on the count present during an enabled clock. The pin takes its new value at that clock edge.
- R11: While the count enable is low, the count, the direction and all pins stay unchanged.
- R12: Synchronous reset clears the count, sets the direction to rising, drives all pins to 0 and clears the buffered compare values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; freezes the timer when low |
| top_val | input | 16 | Turnaround value of the sweep |
| cmp_a | input | 16 | Compare input, channel A |
| cmp_b | input | 16 | Compare input, channel B |
| cmp_c | input | 16 | Compare input, channel C |
| mode_a | input | 2 | Output-mode code, channel A |
| mode_b | input | 2 | Output-mode code, channel B |
| mode_c | input | 2 | Output-mode code, channel C |
| wave_sel | input | 4 | Waveform select; 9 or 11 enables the toggle on A |
| pin_a | output | 1 | Compare output, channel A |
| pin_b | output | 1 | Compare output, channel B |
| pin_c | output | 1 | Compare output, channel C |
| oe_a | output | 1 | Timer owns pin A |
| oe_b | output | 1 | Timer owns pin B |
| oe_c | output | 1 | Timer owns pin C |

## Verification
The hardest situation to reach is a compare change that lands in the middle of a sweep. The new value must stay invisible until the count next reaches TOP, so the old pulse edges have to persist for the rest of the period. The bench writes a new compare value a few clocks into a rising slope and then runs through the next turnaround. A cycle-accurate model tracks the buffered value on its own, so any early load shows up as a moved pin edge. The two end-of-range cases are reached the same way: a compare value equal to TOP, and a compare value of zero. TOP is also lowered to 0 to stall the count at the bottom.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    localparam int NUM_CH   = 3;
    localparam int WAVE_W   = 4;
    localparam int MODE_W   = 2;

    localparam logic [WAVE_W-1:0] WAVE_TOG_LO = 4'd9;
    localparam logic [WAVE_W-1:0] WAVE_TOG_HI = 4'd11;

    typedef enum logic [MODE_W-1:0] {
        COM_OFF    = 2'b00,
        COM_TOGGLE = 2'b01,
        COM_NONINV = 2'b10,
        COM_INV    = 2'b11
    } com_mode_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TOG  = 2'd3
    } pin_act_e;

    typedef struct packed {
        logic drive;
        logic toggle;
        logic inv;
    } ch_ctl_t;

    typedef struct packed {
        logic full;
        logic zero;
        logic match;
        logic rising;
    } cmp_flags_t;

    function automatic logic wave_allows_toggle(input logic [WAVE_W-1:0] w);
        return (w == WAVE_TOG_LO) || (w == WAVE_TOG_HI);
    endfunction

    function automatic ch_ctl_t decode_mode(input logic [MODE_W-1:0] m,
                                            input logic [WAVE_W-1:0] w,
                                            input logic              is_a);
        ch_ctl_t c;
        c = '0;
        case (m)
            COM_TOGGLE: begin
                if (is_a && wave_allows_toggle(w)) begin
                    c.drive  = 1'b1;
                    c.toggle = 1'b1;
                end
            end
            COM_NONINV: c.drive = 1'b1;
            COM_INV: begin
                c.drive = 1'b1;
                c.inv   = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic pin_act_e pick_action(input ch_ctl_t    c,
                                             input cmp_flags_t f);
        pin_act_e a;
        a = ACT_HOLD;
        if (!c.drive) begin
            a = ACT_HOLD;
        end else if (c.toggle) begin
            a = f.match ? ACT_TOG : ACT_HOLD;
        end else if (f.full) begin
            a = c.inv ? ACT_CLR : ACT_SET;
        end else if (f.zero) begin
            a = c.inv ? ACT_SET : ACT_CLR;
        end else if (f.match) begin
            if (f.rising) a = c.inv ? ACT_SET : ACT_CLR;
            else          a = c.inv ? ACT_CLR : ACT_SET;
        end
        return a;
    endfunction

endpackage

// File: rtl/dslope_counter.sv
module dslope_counter
    import dslope_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt,
    output logic         dir_up,
    output logic         at_top
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    dir_e         dir_q;
    logic         top_zero;
    logic         reached_top;
    logic         reached_bot;

    assign top_zero    = (top_val == '0);
    assign reached_top = (dir_q == DIR_UP) && (cnt_q >= top_val);
    assign reached_bot = (dir_q == DIR_DOWN) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (cnt_en) begin
            if (top_zero) begin
                cnt_q <= '0;
                dir_q <= DIR_UP;
            end else if (reached_top) begin
                cnt_q <= cnt_q - ONE;
                dir_q <= DIR_DOWN;
            end else if (reached_bot) begin
                cnt_q <= ONE;
                dir_q <= DIR_UP;
            end else if (dir_q == DIR_UP) begin
                cnt_q <= cnt_q + ONE;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign cnt    = cnt_q;
    assign dir_up = (dir_q == DIR_UP);
    assign at_top = reached_top;

endmodule

// File: rtl/dslope_cmp_buf.sv
module dslope_cmp_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         at_top,
    input  logic [W-1:0] cmp_next,
    output logic [W-1:0] cmp_active
);

    logic [W-1:0] cmp_q;
    logic         load;

    assign load = cnt_en && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (load) begin
            cmp_q <= cmp_next;
        end
    end

    assign cmp_active = cmp_q;

endmodule

// File: rtl/dslope_out_stage.sv
module dslope_out_stage
    import dslope_pkg::*;
#(
    parameter int W    = 16,
    parameter bit IS_A = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic [W-1:0]      cnt,
    input  logic              dir_up,
    input  logic [W-1:0]      top_val,
    input  logic [W-1:0]      cmp_active,
    input  logic [MODE_W-1:0] mode,
    input  logic [WAVE_W-1:0] wave,
    output logic              pin,
    output logic              oe
);

    ch_ctl_t    ctl;
    cmp_flags_t flags;
    pin_act_e   act;
    logic       pin_q;

    always_comb begin
        ctl          = decode_mode(mode, wave, IS_A);
        flags.full   = (cmp_active >= top_val);
        flags.zero   = (cmp_active == '0);
        flags.match  = (cnt == cmp_active);
        flags.rising = dir_up;
        act          = pick_action(ctl, flags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (cnt_en) begin
            case (act)
                ACT_SET:  pin_q <= 1'b1;
                ACT_CLR:  pin_q <= 1'b0;
                ACT_TOG:  pin_q <= ~pin_q;
                default:  pin_q <= pin_q;
            endcase
        end
    end

    assign pin = pin_q;
    assign oe  = ctl.drive;

endmodule

// File: rtl/dslope_pwm.sv
module dslope_pwm
    import dslope_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    input  logic [1:0]       mode_c,
    input  logic [3:0]       wave_sel,
    output logic             pin_a,
    output logic             pin_b,
    output logic             pin_c,
    output logic             oe_a,
    output logic             oe_b,
    output logic             oe_c
);

    logic [CNT_W-1:0]  cnt_w;
    logic              dir_up_w;
    logic              at_top_w;
    logic [CNT_W-1:0]  cmp_in  [NUM_CH];
    logic [CNT_W-1:0]  cmp_act [NUM_CH];
    logic [MODE_W-1:0] mode_in [NUM_CH];
    logic [NUM_CH-1:0] pin_w;
    logic [NUM_CH-1:0] oe_w;
    logic [CNT_W-1:0]  act_a_w;

    assign cmp_in[0]  = cmp_a;
    assign cmp_in[1]  = cmp_b;
    assign cmp_in[2]  = cmp_c;
    assign mode_in[0] = mode_a;
    assign mode_in[1] = mode_b;
    assign mode_in[2] = mode_c;

    dslope_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .top_val (top_val),
        .cnt     (cnt_w),
        .dir_up  (dir_up_w),
        .at_top  (at_top_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dslope_cmp_buf #(.W(CNT_W)) u_buf (
            .clk        (clk),
            .rst        (rst),
            .cnt_en     (cnt_en),
            .at_top     (at_top_w),
            .cmp_next   (cmp_in[g]),
            .cmp_active (cmp_act[g])
        );

        dslope_out_stage #(.W(CNT_W), .IS_A(g == 0)) u_out (
            .clk        (clk),
            .rst        (rst),
            .cnt_en     (cnt_en),
            .cnt        (cnt_w),
            .dir_up     (dir_up_w),
            .top_val    (top_val),
            .cmp_active (cmp_act[g]),
            .mode       (mode_in[g]),
            .wave       (wave_sel),
            .pin        (pin_w[g]),
            .oe         (oe_w[g])
        );
    end

    assign act_a_w = cmp_act[0];

    assign pin_a = pin_w[0];
    assign pin_b = pin_w[1];
    assign pin_c = pin_w[2];
    assign oe_a  = oe_w[0];
    assign oe_b  = oe_w[1];
    assign oe_c  = oe_w[2];

endmodule

// File: rtl/dslope_pwm_chk.sv
module dslope_pwm_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic [W-1:0] top_val,
    input logic [1:0]   mode_a,
    input logic [1:0]   mode_b,
    input logic [3:0]   wave_sel,
    input logic [W-1:0] cnt,
    input logic         dir_up,
    input logic [W-1:0] act_a,
    input logic         pin_a,
    input logic         pin_b,
    input logic         oe_a,
    input logic         oe_b
);

    AST_DISC_NO_OE: assert property (@(posedge clk) disable iff (rst)
        (mode_a == 2'b00) |-> !oe_a); // R1

    AST_SIDE_NO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (mode_b == 2'b01) |-> !oe_b); // R4

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && mode_a == 2'b01 && wave_sel == 4'd9 && cnt == act_a)
        |=> (pin_a != $past(pin_a))); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_up && cnt < top_val) |=> (cnt == W'($past(cnt) + W'(1)))); // R8

    AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && dir_up && cnt >= top_val && top_val != '0) |=> !dir_up); // R8

    AST_FULL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && mode_a == 2'b10 && act_a >= top_val) |=> pin_a); // R6

    AST_LOAD_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        !(cnt_en && dir_up && cnt >= top_val) |=> (act_a == $past(act_a))); // R9

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> (cnt == $past(cnt) && pin_a == $past(pin_a)
                     && pin_b == $past(pin_b))); // R11

endmodule

bind dslope_pwm dslope_pwm_chk #(.W(CNT_W)) u_dslope_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .top_val  (top_val),
    .mode_a   (mode_a),
    .mode_b   (mode_b),
    .wave_sel (wave_sel),
    .cnt      (cnt_w),
    .dir_up   (dir_up_w),
    .act_a    (act_a_w),
    .pin_a    (pin_a),
    .pin_b    (pin_b),
    .oe_a     (oe_a),
    .oe_b     (oe_b)
);

// File: tb/test_dslope_pwm.sv
`timescale 1ns/1ps
module test_dslope_pwm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic [15:0] top_val = 16'd10;
    logic [15:0] cmp_v [3];
    logic [1:0]  mode_v [3];
    logic [3:0]  wave_sel = 4'd0;
    logic        pin_a, pin_b, pin_c, oe_a, oe_b, oe_c;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dslope_pwm i_dslope_pwm (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .top_val(top_val),
        .cmp_a(cmp_v[0]), .cmp_b(cmp_v[1]), .cmp_c(cmp_v[2]),
        .mode_a(mode_v[0]), .mode_b(mode_v[1]), .mode_c(mode_v[2]),
        .wave_sel(wave_sel),
        .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
    );

    // Reference model built from the requirements
    logic [15:0] m_cnt = '0;
    logic        m_up  = 1'b1;
    logic [15:0] m_act [3];
    logic [2:0]  m_pin = '0;

    function automatic logic tog_wave(input logic [3:0] w);
        return (w == 4'd9) || (w == 4'd11);
    endfunction

    function automatic logic exp_oe(input int ch);
        case (mode_v[ch])
            2'b10, 2'b11: return 1'b1;
            2'b01:        return (ch == 0) && tog_wave(wave_sel);
            default:      return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0;
            m_up  = 1'b1;
            m_pin = '0;
            for (int k = 0; k < 3; k++) m_act[k] = '0;
        end else if (cnt_en) begin
            logic turn;
            turn = m_up && (m_cnt >= top_val);
            for (int k = 0; k < 3; k++) begin
                case (mode_v[k])
                    2'b10: begin
                        if (m_act[k] >= top_val)         m_pin[k] = 1'b1;
                        else if (m_act[k] == 16'd0)      m_pin[k] = 1'b0;
                        else if (m_cnt == m_act[k])      m_pin[k] = !m_up;
                    end
                    2'b11: begin
                        if (m_act[k] >= top_val)         m_pin[k] = 1'b0;
                        else if (m_act[k] == 16'd0)      m_pin[k] = 1'b1;
                        else if (m_cnt == m_act[k])      m_pin[k] = m_up;
                    end
                    2'b01: begin
                        if (k == 0 && tog_wave(wave_sel) && m_cnt == m_act[k])
                            m_pin[k] = !m_pin[k];
                    end
                    default: ;
                endcase
            end
            if (turn) for (int k = 0; k < 3; k++) m_act[k] = cmp_v[k];
            if (top_val == 16'd0) begin
                m_cnt = '0;
                m_up  = 1'b1;
            end else if (turn) begin
                m_cnt = m_cnt - 16'd1;
                m_up  = 1'b0;
            end else if (!m_up && m_cnt == 16'd0) begin
                m_cnt = 16'd1;
                m_up  = 1'b1;
            end else if (m_up) begin
                m_cnt = m_cnt + 16'd1;
            end else begin
                m_cnt = m_cnt - 16'd1;
            end
        end
    end

    task automatic check_now(input string req);
        logic [5:0] got, exp;
        got = {pin_c, pin_b, pin_a, oe_c, oe_b, oe_a};
        exp = {m_pin[2], m_pin[1], m_pin[0], exp_oe(2), exp_oe(1), exp_oe(0)};
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: pins/oe actual %b expected %b", req, $time, got, exp);
        end
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now(req);
        end
    endtask

    task automatic set_ch(input int ch, input logic [1:0] m, input logic [15:0] c);
        mode_v[ch] = m;
        cmp_v[ch]  = c;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cnt_en = 1'b0;
        for (int k = 0; k < 3; k++) set_ch(k, 2'b00, 16'd0);
        repeat (3) @(negedge clk);
        check_now("R12");
        rst = 1'b0;
        run(2, "R12 R1");
    endtask

    task automatic t_pwm();
        top_val = 16'd10;
        set_ch(0, 2'b10, 16'd3);
        set_ch(1, 2'b11, 16'd7);
        set_ch(2, 2'b10, 16'd5);
        cnt_en = 1'b1;
        run(70, "R2 R3 R8 R10");
    endtask

    task automatic t_toggle();
        top_val  = 16'd6;
        wave_sel = 4'd9;
        set_ch(0, 2'b01, 16'd2);
        set_ch(1, 2'b01, 16'd4);
        set_ch(2, 2'b01, 16'd1);
        run(40, "R4");
        wave_sel = 4'd11;
        run(30, "R4");
        wave_sel = 4'd8;
        run(20, "R5");
        wave_sel = 4'd9;
        set_ch(0, 2'b00, 16'd2);
        run(20, "R1");
    endtask

    task automatic t_edges();
        top_val = 16'd8;
        set_ch(0, 2'b10, 16'd8);
        set_ch(1, 2'b11, 16'd8);
        set_ch(2, 2'b10, 16'd0);
        run(40, "R6 R7");
        set_ch(0, 2'b11, 16'd12);
        set_ch(1, 2'b10, 16'd20);
        set_ch(2, 2'b11, 16'd0);
        run(40, "R6 R7");
        top_val = 16'd0;
        run(12, "R8 R6");
        top_val = 16'd5;
        set_ch(0, 2'b10, 16'd2);
        set_ch(1, 2'b11, 16'd3);
        set_ch(2, 2'b10, 16'd4);
        run(30, "R8");
    endtask

    task automatic t_reload();
        top_val = 16'd12;
        set_ch(0, 2'b10, 16'd4);
        set_ch(1, 2'b11, 16'd6);
        set_ch(2, 2'b10, 16'd8);
        run(30, "R9");
        set_ch(0, 2'b10, 16'd9);
        set_ch(1, 2'b11, 16'd2);
        set_ch(2, 2'b10, 16'd11);
        run(60, "R9");
    endtask

    task automatic t_hold();
        run(5, "R11");
        cnt_en = 1'b0;
        set_ch(0, 2'b11, 16'd1);
        run(15, "R11");
        cnt_en = 1'b1;
        run(40, "R11 R10");
    endtask

    initial begin
        t_reset();
        t_pwm();
        t_toggle();
        t_edges();
        t_reload();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule